// File: doc/BRIEF.md
# Periodic Self-Test Sequencer

This block runs short built-in self-test windows on a trigger logic path and the concentrator stage that follows it. Windows repeat at a low, fixed rate, so the lost trigger time fits inside a dead period the system already tolerates. During a window, the normal trigger output is suppressed. A 16-bit pseudo-random stimulus is sent into the logic under test, which is the trigger stage followed by the concentrator stage. The word that comes back is compared against a reference copy of that chain kept inside the block.

A window starts in one of two ways. A peer controller can ask for one with a single-cycle request, so that tests fall in with normal running. Alternatively, with the autonomous mode input held high, an internal timer starts a window once per period, and each window started this way is tallied.

The rate and the window length are given in hertz and microseconds and turn into cycle counts through the clock frequency parameter. Every returned word that is wrong, or that is missing, is counted as a detected fault.

Top module: `selftest_seq`

## Requirements
- R1: A window is WIN = CLK_HZ*WIN_US/1e6 cycles long, with integer division. `testStimValid` is high for exactly WIN consecutive cycles. `busy` is high for those cycles plus the FLUSH_CYC (default 4) cycles that follow.
- R2: When `autoMode` is high, a window starts whenever PERIOD = CLK_HZ/RATE_HZ cycles have passed since the previous start. The first `busy` cycle is the cycle after the start is decided.
- R3: A `peerReq` pulse starts a window in the next cycle if PERIOD cycles have passed since the last start and the block is idle. Otherwise the request is held and served at the first allowed cycle. A request is never lost, and several requests that wait together are served by one window. The first start after reset is allowed at once.
- R4: In a cycle where `busy` is low, `trigInValid`/`trigInData` appear one cycle later on `trigOutValid`/`trigOutData`. A valid input taken in a `busy` cycle gives `trigOutValid` low in the next cycle.
- R5: The stimulus comes from a 16-bit LFSR, reseeded to 16'hACE1 at every window start, so the first word of each window is 16'hACE1. Each next word is {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R6: The expected response to a stimulus word x is c = y ^ {y[14:0],1'b0} followed by {c[7:0],c[15:8]} ^ 16'h5A3C, where y = x. It is due RESP_LAT cycles after the stimulus. A due word whose `testRespValid` is low, or whose `testRespData` differs, increments `errCnt` at the next edge.
- R7: `errCnt` accumulates over all windows and saturates at 255.
- R8: `faultFlag` rises in the cycle after a mismatch. It stays high until the next window begins, and is low in that window's first `busy` cycle.
- R9: `autoRunCnt` increments, saturating at 255, for each window started while no peer request was waiting or arriving. Windows that serve a peer request are not counted.
- R10: `testDone` is a one-cycle pulse in the last `busy` cycle of every window.
- R11: During and just after reset, `busy`, `testStimValid`, `trigOutValid`, `testDone` and `faultFlag` are low, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| autoMode | input | 1 | Timer-driven windows enabled |
| peerReq | input | 1 | Test request pulse from peer controller |
| trigInValid | input | 1 | Normal trigger result valid |
| trigInData | input | TRIG_W | Normal trigger result |
| trigOutValid | output | 1 | Forwarded trigger valid, blanked while busy |
| trigOutData | output | TRIG_W | Forwarded trigger result |
| testStimValid | output | 1 | Stimulus word valid |
| testStimData | output | 16 | Stimulus word to the logic under test |
| testRespValid | input | 1 | Response word valid from the concentrator |
| testRespData | input | 16 | Response word from the concentrator |
| busy | output | 1 | Window or flush in progress |
| testDone | output | 1 | Last busy cycle of a window |
| faultFlag | output | 1 | Mismatch seen since the current window began |
| errCnt | output | ERR_W | Saturating mismatch count |
| autoRunCnt | output | REC_W | Saturating count of self-started windows |

## Verification
The collision to watch is a peer request that arrives in the same cycle the autonomous timer becomes due. The bench finds the cycle by counting from a `testDone` pulse to the next due start and drives `peerReq` exactly there. A second request is driven a few cycles early. In both cases a single window must start on time, and `autoRunCnt` must not move, because the window serves the peer. The behavioural model judges every cycle, and directed checks confirm the count.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

  localparam int STIM_W = 16;
  localparam logic [STIM_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [STIM_W-1:0] CONC_MASK = 16'h5A3C;

  typedef logic [STIM_W-1:0] word_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_FLUSH = 2'd2
  } phase_e;

  // strobes from the scheduler to the datapath
  typedef struct packed {
    logic winStart;  // window begins at the coming edge
    logic stimEn;    // stimulus word presented this cycle
    logic blank;     // window or flush in progress
  } ctrlStrobe_t;

  function automatic word_t lfsrStep(input word_t s);
    return {s[STIM_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic word_t trigModel(input word_t x);
    return x ^ {x[STIM_W-2:0], 1'b0};
  endfunction

  function automatic word_t concModel(input word_t y);
    return {y[7:0], y[15:8]} ^ CONC_MASK;
  endfunction

  function automatic word_t expectWord(input word_t x);
    return concModel(trigModel(x));
  endfunction

endpackage

// File: rtl/selftest_ctrl.sv
module selftest_ctrl
  import selftest_pkg::*;
#(
  parameter int PERIOD    = 1000,
  parameter int WIN       = 88,
  parameter int FLUSH_CYC = 4,
  parameter int REC_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             autoMode,
  input  logic             peerReq,
  output ctrlStrobe_t      strobe,
  output logic             testDone,
  output logic [REC_W-1:0] autoRunCnt
);

  localparam int GAP_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int PH_W  = $clog2(WIN + FLUSH_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(PERIOD - 1);
  localparam logic [PH_W-1:0]  RUN_LAST = PH_W'(WIN - 1);
  localparam logic [PH_W-1:0]  FL_LAST  = PH_W'(FLUSH_CYC - 1);
  localparam logic [REC_W-1:0] REC_MAX  = '1;

  phase_e           phase;
  logic [PH_W-1:0]  phCnt;
  logic [GAP_W-1:0] gapCnt;
  logic             pending;
  logic             gapReady;
  logic             reqSeen;
  logic             startNow;

  assign gapReady = (gapCnt == GAP_LAST);
  assign reqSeen  = pending | peerReq;
  assign startNow = (phase == PH_IDLE) && gapReady && (autoMode || reqSeen);

  // spacing between window starts, and held peer requests
  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt  <= GAP_LAST;
      pending <= 1'b0;
    end else begin
      pending <= startNow ? 1'b0 : reqSeen;
      if (startNow)
        gapCnt <= '0;
      else if (!gapReady)
        gapCnt <= gapCnt + 1'b1;
    end
  end

  // window and flush phases
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      phCnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (startNow) begin
            phase <= PH_RUN;
            phCnt <= '0;
          end
        end
        PH_RUN: begin
          if (phCnt == RUN_LAST) begin
            phase <= PH_FLUSH;
            phCnt <= '0;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        PH_FLUSH: begin
          if (phCnt == FL_LAST) begin
            phase <= PH_IDLE;
            phCnt <= '0;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          phCnt <= '0;
        end
      endcase
    end
  end

  // record of windows the timer started by itself
  always_ff @(posedge clk) begin
    if (rst)
      autoRunCnt <= '0;
    else if (startNow && !reqSeen && (autoRunCnt != REC_MAX))
      autoRunCnt <= autoRunCnt + 1'b1;
  end

  always_comb begin
    strobe.winStart = startNow;
    strobe.stimEn   = (phase == PH_RUN);
    strobe.blank    = (phase != PH_IDLE);
  end

  assign testDone = (phase == PH_FLUSH) && (phCnt == FL_LAST);

endmodule

// File: rtl/selftest_dp.sv
module selftest_dp
  import selftest_pkg::*;
#(
  parameter int TRIG_W   = 32,
  parameter int RESP_LAT = 3,
  parameter int ERR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic              trigInValid,
  input  logic [TRIG_W-1:0] trigInData,
  output logic              trigOutValid,
  output logic [TRIG_W-1:0] trigOutData,
  output logic              testStimValid,
  output word_t             testStimData,
  input  logic              testRespValid,
  input  word_t             testRespData,
  output logic              faultFlag,
  output logic [ERR_W-1:0]  errCnt
);

  localparam int LAST = RESP_LAT - 1;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  word_t lfsr;
  logic  refV [RESP_LAT];
  word_t refD [RESP_LAT];
  logic  mismatch;

  // stimulus generator, restarted at every window
  always_ff @(posedge clk) begin
    if (rst || strobe.winStart)
      lfsr <= LFSR_SEED;
    else if (strobe.stimEn)
      lfsr <= lfsrStep(lfsr);
  end

  assign testStimValid = strobe.stimEn;
  assign testStimData  = lfsr;

  // reference copy of the tested chain, delayed to the response slot
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RESP_LAT; i++) begin
        refV[i] <= 1'b0;
        refD[i] <= '0;
      end
    end else begin
      refV[0] <= strobe.stimEn;
      refD[0] <= expectWord(lfsr);
      for (int i = 1; i < RESP_LAT; i++) begin
        refV[i] <= refV[i-1];
        refD[i] <= refD[i-1];
      end
    end
  end

  assign mismatch = refV[LAST] && (!testRespValid || (testRespData != refD[LAST]));

  always_ff @(posedge clk) begin
    if (rst) begin
      errCnt    <= '0;
      faultFlag <= 1'b0;
    end else begin
      if (mismatch && (errCnt != ERR_MAX))
        errCnt <= errCnt + 1'b1;
      if (strobe.winStart)
        faultFlag <= 1'b0;
      else if (mismatch)
        faultFlag <= 1'b1;
    end
  end

  // normal trigger path, blanked for the window and its flush
  always_ff @(posedge clk) begin
    if (rst) begin
      trigOutValid <= 1'b0;
      trigOutData  <= '0;
    end else begin
      trigOutValid <= trigInValid && !strobe.blank;
      trigOutData  <= trigInData;
    end
  end

endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int CLK_HZ    = 40_000_000,
  parameter int RATE_HZ   = 10,
  parameter int WIN_US    = 88,
  parameter int FLUSH_CYC = 4,
  parameter int RESP_LAT  = 3,
  parameter int TRIG_W    = 32,
  parameter int ERR_W     = 8,
  parameter int REC_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              autoMode,
  input  logic              peerReq,
  input  logic              trigInValid,
  input  logic [TRIG_W-1:0] trigInData,
  output logic              trigOutValid,
  output logic [TRIG_W-1:0] trigOutData,
  output logic              testStimValid,
  output logic [15:0]       testStimData,
  input  logic              testRespValid,
  input  logic [15:0]       testRespData,
  output logic              busy,
  output logic              testDone,
  output logic              faultFlag,
  output logic [ERR_W-1:0]  errCnt,
  output logic [REC_W-1:0]  autoRunCnt
);

  localparam longint WIN_L  = (longint'(CLK_HZ) * longint'(WIN_US)) / 64'd1_000_000;
  localparam int     WIN    = int'(WIN_L);
  localparam int     PERIOD = CLK_HZ / RATE_HZ;

  ctrlStrobe_t strobe;

  selftest_ctrl #(
    .PERIOD   (PERIOD),
    .WIN      (WIN),
    .FLUSH_CYC(FLUSH_CYC),
    .REC_W    (REC_W)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .autoMode  (autoMode),
    .peerReq   (peerReq),
    .strobe    (strobe),
    .testDone  (testDone),
    .autoRunCnt(autoRunCnt)
  );

  selftest_dp #(
    .TRIG_W  (TRIG_W),
    .RESP_LAT(RESP_LAT),
    .ERR_W   (ERR_W)
  ) i_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .trigInValid  (trigInValid),
    .trigInData   (trigInData),
    .trigOutValid (trigOutValid),
    .trigOutData  (trigOutData),
    .testStimValid(testStimValid),
    .testStimData (testStimData),
    .testRespValid(testRespValid),
    .testRespData (testRespData),
    .faultFlag    (faultFlag),
    .errCnt       (errCnt)
  );

  assign busy = strobe.blank;

endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk #(
  parameter int ERR_W = 8,
  parameter int REC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             trigOutValid,
  input logic             testStimValid,
  input logic [15:0]      testStimData,
  input logic             testDone,
  input logic             faultFlag,
  input logic [ERR_W-1:0] errCnt,
  input logic [REC_W-1:0] autoRunCnt
);

  // R4: nothing is forwarded from a busy cycle
  a_r4_blank_trig: assert property (@(posedge clk) disable iff (rst)
    busy |=> !trigOutValid);

  // R1: stimulus only inside a busy interval
  a_r1_stim_in_busy: assert property (@(posedge clk) disable iff (rst)
    testStimValid |-> busy);

  // R5: every window opens with the seed word
  a_r5_seed_first: assert property (@(posedge clk) disable iff (rst)
    $rose(testStimValid) |-> (testStimData == 16'hACE1));

  // R6: the error count never decreases
  a_r6_err_no_drop: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (errCnt >= $past(errCnt)));

  // R7: a full count stays full
  a_r7_err_hold: assert property (@(posedge clk) disable iff (rst)
    (errCnt == {ERR_W{1'b1}}) |=> (errCnt == {ERR_W{1'b1}}));

  // R8: a new error raises the fault flag
  a_r8_fault_on_err: assert property (@(posedge clk) disable iff (rst)
    $changed(errCnt) |-> faultFlag);

  // R9: the self-start record moves by at most one per cycle
  a_r9_auto_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((autoRunCnt == $past(autoRunCnt)) ||
              (autoRunCnt == $past(autoRunCnt) + REC_W'(1))));

  // R10: single-cycle done, then idle
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    testDone |=> (!testDone && !busy));

endmodule

bind selftest_seq selftest_seq_chk #(
  .ERR_W(ERR_W),
  .REC_W(REC_W)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .trigOutValid (trigOutValid),
  .testStimValid(testStimValid),
  .testStimData (testStimData),
  .testDone     (testDone),
  .faultFlag    (faultFlag),
  .errCnt       (errCnt),
  .autoRunCnt   (autoRunCnt)
);

// File: tb/test_selftest_seq.sv
`timescale 1ns/1ps
module test_selftest_seq;

  localparam int CLK_HZ   = 1_000_000;
  localparam int RATE_HZ  = 1000;
  localparam int WIN_US   = 88;
  localparam int FLUSH    = 4;
  localparam int LAT      = 3;
  localparam int TRIG_W   = 32;
  localparam int PERIOD   = CLK_HZ / RATE_HZ;        // 1000
  localparam int WIN      = CLK_HZ / 1000 * WIN_US / 1000; // 88
  localparam int WATCHDOG = 200_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic autoMode = 1'b0;
  logic peerReq = 1'b0;
  logic trigInValid = 1'b0;
  logic [TRIG_W-1:0] trigInData = '0;
  logic trigOutValid;
  logic [TRIG_W-1:0] trigOutData;
  logic testStimValid;
  logic [15:0] testStimData;
  logic testRespValid;
  logic [15:0] testRespData;
  logic busy, testDone, faultFlag;
  logic [7:0] errCnt, autoRunCnt;
  logic [15:0] corruptMask = '0;
  logic dropResp = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  selftest_seq #(
    .CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ), .WIN_US(WIN_US),
    .FLUSH_CYC(FLUSH), .RESP_LAT(LAT), .TRIG_W(TRIG_W), .ERR_W(8), .REC_W(8)
  ) i_selftest_seq (
    .clk(clk), .rst(rst), .autoMode(autoMode), .peerReq(peerReq),
    .trigInValid(trigInValid), .trigInData(trigInData),
    .trigOutValid(trigOutValid), .trigOutData(trigOutData),
    .testStimValid(testStimValid), .testStimData(testStimData),
    .testRespValid(testRespValid), .testRespData(testRespData),
    .busy(busy), .testDone(testDone), .faultFlag(faultFlag),
    .errCnt(errCnt), .autoRunCnt(autoRunCnt)
  );

  // logic under test: two trigger stages, then one concentrator stage
  logic tV1, tV2, cV;
  logic [15:0] tD1, tD2, cD;
  always @(posedge clk) begin
    if (rst) begin
      tV1 <= 0; tV2 <= 0; cV <= 0; tD1 <= 0; tD2 <= 0; cD <= 0;
    end else begin
      tV1 <= testStimValid;
      tD1 <= testStimData ^ (testStimData << 1);
      tV2 <= tV1;
      tD2 <= tD1;
      cV  <= tV2;
      cD  <= {tD2[7:0], tD2[15:8]} ^ 16'h5A3C;
    end
  end
  assign testRespValid = cV & ~dropResp;
  assign testRespData  = cD ^ corruptMask;

  // behavioural reference model
  int mIdx = -1;
  int mSince = PERIOD - 1;
  bit mPend = 0;
  logic [15:0] mLfsr = 16'hACE1;
  int mErr = 0;
  bit mFault = 0;
  int mAuto = 0;
  bit mTrigV = 0;
  logic [TRIG_W-1:0] mTrigD = '0;
  bit mRefV [LAT];

  function automatic logic [15:0] nextWord(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mIdx = -1; mSince = PERIOD - 1; mPend = 0; mLfsr = 16'hACE1;
      mErr = 0; mFault = 0; mAuto = 0; mTrigV = 0; mTrigD = '0;
      for (int i = 0; i < LAT; i++) mRefV[i] = 0;
    end else begin
      bit busyNow, stimNow, reqSeen, start, mis;
      busyNow = (mIdx >= 0);
      stimNow = (mIdx >= 0) && (mIdx < WIN);
      reqSeen = mPend || peerReq;
      start   = !busyNow && (mSince == PERIOD - 1) && (autoMode || reqSeen);
      mis     = mRefV[LAT-1] && (dropResp || (corruptMask != 0));
      if (mis && mErr < 255) mErr++;
      if (start) mFault = 0; else if (mis) mFault = 1;
      if (start && !reqSeen && mAuto < 255) mAuto++;
      mPend  = start ? 1'b0 : reqSeen;
      mTrigV = trigInValid && !busyNow;
      mTrigD = trigInData;
      for (int i = LAT - 1; i > 0; i--) mRefV[i] = mRefV[i-1];
      mRefV[0] = stimNow;
      if (start) mLfsr = 16'hACE1; else if (stimNow) mLfsr = nextWord(mLfsr);
      if (start) mSince = 0; else if (mSince < PERIOD - 1) mSince++;
      if (start) mIdx = 0;
      else if (busyNow) mIdx = (mIdx == WIN + FLUSH - 1) ? -1 : mIdx + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  int winCount = 0;
  bit busyPrev = 0;
  always @(negedge clk) begin
    if (!finished) begin
      bit eBusy, eStim, eDone;
      string rqB, rqS, rqD, rqT, rqE, rqF, rqA;
      eBusy = (mIdx >= 0);
      eStim = (mIdx >= 0) && (mIdx < WIN);
      eDone = (mIdx == WIN + FLUSH - 1);
      rqB = rst ? "R11" : (autoMode ? "R2" : "R3");
      rqS = rst ? "R11" : "R1";
      rqD = rst ? "R11" : "R10";
      rqT = rst ? "R11" : "R4";
      rqE = rst ? "R11" : ((mErr == 255) ? "R7" : "R6");
      rqF = rst ? "R11" : "R8";
      rqA = rst ? "R11" : "R9";
      check(busy === eBusy, rqB, "busy", busy, eBusy);
      check(testStimValid === eStim, rqS, "testStimValid", testStimValid, eStim);
      if (eStim)
        check(testStimData === mLfsr, "R5", "testStimData", testStimData, mLfsr);
      check(testDone === eDone, rqD, "testDone", testDone, eDone);
      check(trigOutValid === mTrigV, rqT, "trigOutValid", trigOutValid, mTrigV);
      if (mTrigV)
        check(trigOutData === mTrigD, "R4", "trigOutData", trigOutData, mTrigD);
      check(errCnt === 8'(mErr), rqE, "errCnt", errCnt, mErr);
      check(faultFlag === mFault, rqF, "faultFlag", faultFlag, mFault);
      check(autoRunCnt === 8'(mAuto), rqA, "autoRunCnt", autoRunCnt, mAuto);
      if (busy && !busyPrev) winCount++;
      busyPrev = busy;
    end
  end

  // normal trigger traffic
  logic [31:0] prng = 32'h1234_5678;
  always @(negedge clk) begin
    prng = prng ^ (prng << 13);
    prng = prng ^ (prng >> 17);
    prng = prng ^ (prng << 5);
    trigInValid <= prng[3] | prng[9];
    trigInData  <= prng;
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseReq();
    peerReq = 1'b1;
    @(negedge clk);
    peerReq = 1'b0;
  endtask

  task automatic waitBusy();
    while (!busy) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic waitDone();
    while (!testDone) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      finish();
    end
  end

  initial begin
    int autoBefore;
    waitCycles(4);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state at the ports
    check(busy == 0 && errCnt == 0 && autoRunCnt == 0 && faultFlag == 0,
          "R11", "post-reset idle", {busy, faultFlag, errCnt, autoRunCnt}, 0);
    waitCycles(20);
    check(winCount == 0, "R3", "no window without request", winCount, 0);

    // R3: served at once, then two requests while busy merge into one window
    pulseReq();
    waitCycles(30);
    pulseReq();
    waitCycles(5);
    pulseReq();
    waitCycles(1200);
    check(winCount == 2, "R3", "held requests served once", winCount, 2);

    // R6/R8: corrupt a few responses inside a window
    pulseReq();
    waitBusy();
    waitCycles(10);
    corruptMask = 16'h0010;
    waitCycles(5);
    corruptMask = 16'h0000;
    waitIdle();
    check(faultFlag == 1'b1, "R8", "flag after corruption", faultFlag, 1);
    check(errCnt == 8'd5, "R6", "five corrupted words", errCnt, 5);

    // R6: missing responses count as well
    pulseReq();
    waitBusy();
    check(faultFlag == 1'b0, "R8", "flag cleared at window start", faultFlag, 0);
    waitCycles(30);
    dropResp = 1'b1;
    waitCycles(3);
    dropResp = 1'b0;
    waitIdle();
    check(errCnt == 8'd8, "R6", "dropped responses", errCnt, 8);

    // R2/R7: autonomous windows with every response wrong
    autoMode = 1'b1;
    corruptMask = 16'hFFFF;
    waitCycles(3500);
    corruptMask = 16'h0000;
    check(errCnt == 8'hFF, "R7", "count saturated", errCnt, 255);
    check(autoRunCnt >= 8'd3, "R2", "timer windows started", autoRunCnt, 3);

    // R9: peer request a little before the timer is due
    waitDone();
    autoBefore = int'(autoRunCnt);
    waitCycles(900);
    pulseReq();
    waitDone();
    check(int'(autoRunCnt) == autoBefore, "R9", "peer window not recorded", autoRunCnt, autoBefore);
    check(faultFlag == 1'b0, "R8", "clean window", faultFlag, 0);

    // R9: peer request in the very cycle the timer is due
    autoBefore = int'(autoRunCnt);
    waitCycles(PERIOD - WIN - FLUSH);
    pulseReq();
    waitDone();
    check(int'(autoRunCnt) == autoBefore, "R9", "same-cycle request", autoRunCnt, autoBefore);

    autoMode = 1'b0;
    waitCycles(1200);
    finish();
  end

endmodule